// File: doc/BRIEF.md
# Dual-Channel CAN Transmit Failover Sequencer

This block sequences one outgoing message across two independent CAN bus channels. Each channel has its own protocol engine. The host writes the message into the shared buffer and raises the channel-1 request. The sequencer then asks engine 1 to send the message. Engine 1 retries on its own for as long as it is healthy. If engine 1 reaches the error-passive condition, the sequencer aborts the message on channel 1 and waits for that abort to be confirmed. It then switches the channel-select line and sends the same buffered message on channel 2, without waiting for a new host request.

After a failover the sequencer stays on the channel-2 side. Further messages are started by the host's channel-2 request. If channel 2 also goes error-passive, the message there is aborted the same way. When that abort is confirmed, the sequencer returns to the channel-1 idle state and raises a sticky dual-failure flag. The host clears the flag. Every successful transmission, on either channel, produces a one-cycle acknowledge pulse and a one-cycle success pulse.

Top module: `can_dual_failover`

## Requirements
- R1: While `rst_ni` is low, every output is low at once, without waiting for a clock edge. The sequencer restarts in the channel-1 idle state, and reset also clears the dual-failure flag.
- R2: In channel-1 idle, a sampled `host_req1_i` raises `tx_req_o[0]` after that edge. `tx_req_o[0]` stays high until an edge samples `eng_ready_i[0]`, and it drops after that edge.
- R3: In a send state, a sampled `eng_tx_ok_i` for the active channel raises `ack_o` and `success_o` together for exactly one cycle. The sequencer then returns to the idle state of the same channel.
- R4: In the channel-1 send state, `eng_err_pas_i[0]` without success raises `abort_o[0]` after the next edge. `abort_o[0]` stays high until an edge samples `eng_abort_done_i[0]`. The done input is ignored on the first abort cycle.
- R5: When an edge samples the channel-1 abort-done, `chan_sel_o` goes high after that edge. One cycle later `tx_req_o[1]` rises, with no host request.
- R6: The channel-2 request is ignored in channel-1 idle. The channel-1 request is ignored in channel-2 idle. Outside a failover, channel-2 idle waits for `host_req2_i`.
- R7: After a successful transmission on channel 2, the sequencer stays on the channel-2 side, with `chan_sel_o` still high.
- R8: In the channel-2 send state, `eng_err_pas_i[1]` without success raises `abort_o[1]` until `eng_abort_done_i[1]` is sampled. After that edge `chan_sel_o` drops and `dual_fail_o` rises.
- R9: `dual_fail_o` stays high until a cycle in which `fail_clear_i` is sampled. If the flag is set and cleared in the same cycle, it stays high.
- R10: If success and error-passive arrive in the same cycle in a send state, success wins. The result is an acknowledge with no abort.
- R11: At most one of `tx_req_o[1:0]`, `abort_o[1:0]` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req1_i | input | 1 | Host asks for a send on channel 1 |
| host_req2_i | input | 1 | Host asks for a send on channel 2 |
| fail_clear_i | input | 1 | Clears the dual-failure flag |
| eng_ready_i | input | 2 | Engine accepts the send request, one bit per channel |
| eng_tx_ok_i | input | 2 | Engine reports a completed send |
| eng_err_pas_i | input | 2 | Engine has reached error-passive |
| eng_abort_done_i | input | 2 | Engine confirms the abort |
| tx_req_o | output | 2 | Send request to each engine |
| abort_o | output | 2 | Abort request to each engine |
| chan_sel_o | output | 1 | High while channel 2 is the active channel |
| ack_o | output | 1 | One-cycle acknowledge on success |
| success_o | output | 1 | One-cycle success pulse |
| dual_fail_o | output | 1 | Sticky flag: both channels have failed |

## Verification
Two events can coincide in one cycle.

The first is success and error-passive arriving together in a send state. The bench drives both in one cycle on each channel. It passes only if an acknowledge pulse follows, no abort line rises, and the sequencer stays on the same channel.

The second is the dual-failure flag being set and cleared together. The bench drives the channel-2 abort-done together with `fail_clear_i`. It passes only if the flag is still high after that edge and goes low only after a later clear.

// File: rtl/can_dual_failover_pkg.sv
package can_dual_failover_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [3:0] {
    S_IDLE1  = 4'd0,
    S_WAIT1  = 4'd1,
    S_CH1    = 4'd2,
    S_ABORT1 = 4'd3,
    S_WAIT2  = 4'd4,
    S_IDLE2  = 4'd5,
    S_WAIT3  = 4'd6,
    S_CH2    = 4'd7,
    S_ABORT2 = 4'd8,
    S_WAIT4  = 4'd9
  } seq_state_e;

  function automatic logic on_ch2_side(seq_state_e s);
    return (s == S_IDLE2) || (s == S_WAIT3) || (s == S_CH2) ||
           (s == S_ABORT2) || (s == S_WAIT4);
  endfunction

endpackage

// File: rtl/cdf_seq.sv
module cdf_seq
  import can_dual_failover_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req1_i,
  input  logic              host_req2_i,
  input  logic [NUM_CH-1:0] ready_i,
  input  logic [NUM_CH-1:0] tx_ok_i,
  input  logic [NUM_CH-1:0] err_pas_i,
  input  logic [NUM_CH-1:0] abort_done_i,
  output seq_state_e        state_o,
  output seq_state_e        next_o,
  output logic              sent_o,
  output logic              both_failed_o
);

  seq_state_e state_q, state_d;
  logic       auto_q;   // idle2 entered straight from wait2

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE1:  if (host_req1_i) state_d = S_WAIT1;
      S_WAIT1:  if (ready_i[0]) state_d = S_CH1;
      S_CH1: begin
        if (tx_ok_i[0])          state_d = S_IDLE1;
        else if (err_pas_i[0])   state_d = S_ABORT1;
      end
      S_ABORT1: state_d = S_WAIT2;
      S_WAIT2:  if (abort_done_i[0]) state_d = S_IDLE2;
      S_IDLE2:  if (auto_q || host_req2_i) state_d = S_WAIT3;
      S_WAIT3:  if (ready_i[1]) state_d = S_CH2;
      S_CH2: begin
        if (tx_ok_i[1])          state_d = S_IDLE2;
        else if (err_pas_i[1])   state_d = S_ABORT2;
      end
      S_ABORT2: state_d = S_WAIT4;
      S_WAIT4:  if (abort_done_i[1]) state_d = S_IDLE1;
      default:  state_d = S_IDLE1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE1;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= (state_q == S_WAIT2) && (state_d == S_IDLE2);
    end
  end

  assign state_o       = state_q;
  assign next_o        = state_d;
  assign sent_o        = ((state_q == S_CH1) && tx_ok_i[0]) ||
                         ((state_q == S_CH2) && tx_ok_i[1]);
  assign both_failed_o = (state_q == S_WAIT4) && abort_done_i[1];

  assert_auto_failover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT2 && abort_done_i[0]) |=> ##1 (state_q == S_WAIT3));

  assert_ok_beats_passive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CH1 && tx_ok_i[0]) |=> (state_q == S_IDLE1));

  assert_ch2_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CH2 && tx_ok_i[1]) |=> (state_q == S_IDLE2));

endmodule

// File: rtl/cdf_chan_drive.sv
module cdf_chan_drive
  import can_dual_failover_pkg::*;
#(
  parameter int unsigned SIDE = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e next_i,
  input  logic       ready_i,
  input  logic       abort_done_i,
  output logic       tx_req_o,
  output logic       abort_o
);

  localparam seq_state_e WAIT_ST  = (SIDE == 0) ? S_WAIT1  : S_WAIT3;
  localparam seq_state_e ABORT_ST = (SIDE == 0) ? S_ABORT1 : S_ABORT2;
  localparam seq_state_e HOLD_ST  = (SIDE == 0) ? S_WAIT2  : S_WAIT4;

  logic tx_req_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_req_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      tx_req_q <= (next_i == WAIT_ST);
      abort_q  <= (next_i == ABORT_ST) || (next_i == HOLD_ST);
    end
  end

  assign tx_req_o = tx_req_q;
  assign abort_o  = abort_q;

  assert_txreq_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_q && !ready_i) |=> tx_req_q);

  assert_abort_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && !abort_done_i) |=> abort_q);

endmodule

// File: rtl/cdf_sticky.sv
module cdf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clear_i) |=> flag_q);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

endmodule

// File: rtl/can_dual_failover.sv
module can_dual_failover
  import can_dual_failover_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_req1_i,
  input  logic       host_req2_i,
  input  logic       fail_clear_i,
  input  logic [1:0] eng_ready_i,
  input  logic [1:0] eng_tx_ok_i,
  input  logic [1:0] eng_err_pas_i,
  input  logic [1:0] eng_abort_done_i,
  output logic [1:0] tx_req_o,
  output logic [1:0] abort_o,
  output logic       chan_sel_o,
  output logic       ack_o,
  output logic       success_o,
  output logic       dual_fail_o
);

  seq_state_e state, nxt;
  logic       sent, both_failed;
  logic       sel_q, ack_q, succ_q;

  cdf_seq i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_req1_i   (host_req1_i),
    .host_req2_i   (host_req2_i),
    .ready_i       (eng_ready_i),
    .tx_ok_i       (eng_tx_ok_i),
    .err_pas_i     (eng_err_pas_i),
    .abort_done_i  (eng_abort_done_i),
    .state_o       (state),
    .next_o        (nxt),
    .sent_o        (sent),
    .both_failed_o (both_failed)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    cdf_chan_drive #(.SIDE(c)) i_drive (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .next_i       (nxt),
      .ready_i      (eng_ready_i[c]),
      .abort_done_i (eng_abort_done_i[c]),
      .tx_req_o     (tx_req_o[c]),
      .abort_o      (abort_o[c])
    );
  end

  cdf_sticky i_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (both_failed),
    .clear_i (fail_clear_i),
    .flag_o  (dual_fail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      ack_q  <= 1'b0;
      succ_q <= 1'b0;
    end else begin
      sel_q  <= on_ch2_side(nxt);
      ack_q  <= sent;
      succ_q <= sent;
    end
  end

  assign chan_sel_o = sel_q;
  assign ack_o      = ack_q;
  assign success_o  = succ_q;

  assert_one_drive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_req_o, abort_o}));

  assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    success_o |=> !success_o);

  assert_sel_before_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_req_o[1]) |-> (chan_sel_o && $past(chan_sel_o)));

  assert_ch2_abort_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o[1] && !eng_abort_done_i[1]) |=> (abort_o[1] && chan_sel_o));

  always_comb begin
    if (rst_ni) assert_reqs_side_R6: assert (!(tx_req_o[1] && state == S_WAIT1));
  end

endmodule

// File: tb/test_can_dual_failover.sv
module test_can_dual_failover;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req1 = 0, req2 = 0, clr = 0;
  logic [1:0] rdy = 0, ok = 0, pas = 0, done = 0;
  logic [1:0] tx_req, abort;
  logic       sel, ack, succ, dual;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  can_dual_failover i_can_dual_failover (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .host_req1_i      (req1),
    .host_req2_i      (req2),
    .fail_clear_i     (clr),
    .eng_ready_i      (rdy),
    .eng_tx_ok_i      (ok),
    .eng_err_pas_i    (pas),
    .eng_abort_done_i (done),
    .tx_req_o         (tx_req),
    .abort_o          (abort),
    .chan_sel_o       (sel),
    .ack_o            (ack),
    .success_o        (succ),
    .dual_fail_o      (dual)
  );

  // stim: clr done2 done1 pas2 pas1 ok2 ok1 rdy2 rdy1 req2 req1
  // exp : dual sel ab2 ab1 tx2 tx1 succ ack
  localparam int NROW = 30;
  localparam logic [18:0] VEC [NROW] = '{
    19'b00000000000_00000000, // 0  R1 idle
    19'b00000000010_00000000, // 1  R6 req2 ignored in idle1
    19'b00000000001_00000100, // 2  R2 request ch1
    19'b00000000000_00000100, // 3  R2 held
    19'b00000000100_00000000, // 4  R2 drops on ready
    19'b00000010000_00000011, // 5  R3 success
    19'b00000000000_00000000, // 6  R3 single pulse
    19'b00000000001_00000100, // 7  R2
    19'b00000000100_00000000, // 8  R2
    19'b00000000000_00000000, // 9  R4 sending
    19'b00001000000_00010000, // 10 R4 passive -> abort
    19'b00000000000_00010000, // 11 R4 held
    19'b00100000000_01000000, // 12 R5 select ch2
    19'b00000000000_01001000, // 13 R5 auto request ch2
    19'b00000001000_01000000, // 14 R5
    19'b00000100000_01000011, // 15 R7 ch2 success
    19'b00000000001_01000000, // 16 R6 req1 ignored in idle2
    19'b00000000010_01001000, // 17 R6 req2 starts
    19'b00000001000_01000000, // 18 R7
    19'b00010100000_01000011, // 19 R10 ok2 beats pas2
    19'b00000000010_01001000, // 20 R8
    19'b00000001000_01000000, // 21 R8
    19'b00010000000_01100000, // 22 R8 abort ch2
    19'b00000000000_01100000, // 23 R8 held
    19'b01000000000_10000000, // 24 R8 dual fail
    19'b00000000000_10000000, // 25 R9 sticky
    19'b10000000000_00000000, // 26 R9 cleared
    19'b00000000001_00000100, // 27 R2
    19'b00000000100_00000000, // 28 R2
    19'b00001010000_00000011  // 29 R10 ok1 beats pas1
  };
  localparam int ROW_REQ [NROW] = '{1,6,2,2,2,3,3,2,2,4,4,4,5,5,5,7,6,6,7,10,8,8,8,8,8,9,9,2,2,10};

  function automatic logic [7:0] outs();
    return {dual, sel, abort[1], abort[0], tx_req[1], tx_req[0], succ, ack};
  endfunction

  task automatic apply(input logic [10:0] s);
    {clr, done[1], done[0], pas[1], pas[0], ok[1], ok[0], rdy[1], rdy[0], req2, req1} = s;
  endtask

  task automatic cycle(input logic [10:0] s);
    apply(s);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    n_cmp++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, outs(), exp);
    end
  endtask

  initial begin
    #5;
    check("R1 in reset", 8'b0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    check("R1 after release", 8'b0);

    for (int i = 0; i < NROW; i++) begin
      cycle(VEC[i][18:8]);
      n_cmp++;
      if (outs() !== VEC[i][7:0]) begin
        n_bad++;
        $display("FAIL R%0d row %0d actual=%b expected=%b", ROW_REQ[i], i, outs(), VEC[i][7:0]);
      end
    end

    // R9: set and clear in the same cycle, set wins
    cycle(11'b00000000001);
    cycle(11'b00000000100);
    cycle(11'b00001000000);
    cycle(11'b00000000000);
    cycle(11'b00100000000);
    check("R5 select", 8'b01000000);
    cycle(11'b00000000000);
    cycle(11'b00000001000);
    cycle(11'b00010000000);
    check("R8 abort ch2", 8'b01100000);
    cycle(11'b00000000000);
    cycle(11'b11000000000);
    check("R9 set beats clear", 8'b10000000);
    cycle(11'b00000000000);
    check("R9 still set", 8'b10000000);

    // R1: asynchronous reset mid-request clears flag and outputs
    cycle(11'b00000000001);
    check("R2 request with flag", 8'b10000100);
    apply(11'b0);
    #3;
    rst_ni = 1'b0;
    #2;
    check("R1 async reset", 8'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    cycle(11'b00000000010);
    check("R6 req2 after reset", 8'b0);
    cycle(11'b00000000001);
    check("R2 restart ch1", 8'b00000100);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule